// File: doc/BRIEF.md
# Write Protection Register Unit

This unit guards the writable area of a small serial memory. It holds a lower-bound address, a protection flag and a one-time lock bit. When the flag is clear, every word at or above the bound is protected, up to the top of memory. The serial controller decodes each protection instruction and hands it to this unit as a one-cycle strobe when chip select falls. The unit answers with an accept or reject pulse and updates its state.

Changes to the register follow a strict order. The write-enable latch must already be set. A protection-enable instruction then arms the unit. The very next instruction may change the bound, clear it, or lock it. Once the lock is set, the bound and flag are frozen until power-on reset.

The unit also answers write requests for the memory array. It has a combinational check for a single word, for a page of up to four words that wrap inside an aligned group, and for a whole-array fill. For readout it presents a frame made of a zero lead bit, the bound (most significant bit first) and then the flag.

Top module: `wprot_unit`

## Requirements
- R1: After power-on reset the bound is all ones, the flag is 1 and the lock is 0. `rd_frame` equals {0, bound, flag}, which is 10'h1FF, and no address is protected.
- R2: While the flag is 0, `chk_prot` is 1 exactly when `chk_addr` is greater than or equal to the bound. While the flag is 1, it is 0 for every address.
- R3: Command code 1 (arm) is accepted only while `wel`, `pre_pin` and `w_pin` are all high, and it leaves the bound and flag unchanged. Otherwise it is rejected.
- R4: Command code 2 (set bound) is accepted only when the instruction just before it was an accepted arm, with `pre_pin` and `w_pin` high and the lock clear. It then stores `cmd_addr` as the bound and sets the flag to 0. A preceding clear is not needed.
- R5: Command code 3 (clear) uses the same gating as R4. It sets the bound to all ones and the flag to 1.
- R6: Any instruction between an arm and a change discards the authorisation. This includes code 0 (other), a read, or a rejected command, so a following set bound or clear is rejected and the register keeps its value.
- R7: Command code 4 (lock) uses the same gating as R4 and sets the lock bit. From then on, set bound, clear and lock are rejected and the bound and flag stay the same. Only `por_n` clears the lock.
- R8: Command code 5 (read) is accepted only with `pre_pin` high. `rd_frame` is {1'b0, bound[7:0], flag}, and it is shifted out from bit 9 down to bit 0.
- R9: A page check with `chk_words` = n-1 covers n words. Word i has the upper address bits of `chk_addr`, and its low two bits are `chk_addr[1:0]`+i modulo 4. `chk_ok` is 0 if any covered word is protected.
- R10: With `chk_all` high, `chk_ok` equals the flag, so a whole-array fill is allowed only in the cleared state.
- R11: Every command with codes 1 to 5 gives exactly one of `cmd_acc` or `cmd_rej` for one cycle, right after the strobe edge. Codes 0, 6 and 7 give neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset; the only way to clear the lock |
| cmd_valid | input | 1 | One-cycle strobe for a decoded instruction |
| cmd_op | input | 3 | 0 other, 1 arm, 2 set bound, 3 clear, 4 lock, 5 read |
| cmd_addr | input | 8 | Address field of the instruction |
| wel | input | 1 | Write-enable latch state |
| w_pin | input | 1 | Write-enable pin level |
| pre_pin | input | 1 | Protection-enable pin level |
| chk_addr | input | 8 | First word address of a write request |
| chk_words | input | 2 | Number of page words minus one |
| chk_all | input | 1 | Request is a whole-array fill |
| chk_prot | output | 1 | `chk_addr` is protected |
| chk_ok | output | 1 | Request may be committed |
| rd_frame | output | 10 | Readout frame {0, bound, flag} |
| cmd_acc | output | 1 | Command accepted (one cycle) |
| cmd_rej | output | 1 | Command rejected (one cycle) |

## Verification
Register state, `cmd_acc` and `cmd_rej` all change on the same rising edge that samples `cmd_valid`. The bench therefore raises the strobe at a falling edge and checks the response and `rd_frame` at the next falling edge, one cycle later. `chk_prot` and `chk_ok` are combinational, so the bench checks them a short delay after changing the request inputs, with no clock in between. The arming tests issue each instruction in its own cycle, so the effect of "the previous instruction" can be seen in the order the commands were sent.

// File: rtl/wprot_unit.sv
module wprot_unit #(
  parameter int AW   = 8,
  parameter int PAGE = 4
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [AW-1:0]           cmd_addr,
  input  logic                    wel,
  input  logic                    w_pin,
  input  logic                    pre_pin,
  input  logic [AW-1:0]           chk_addr,
  input  logic [$clog2(PAGE)-1:0] chk_words,
  input  logic                    chk_all,
  output logic                    chk_prot,
  output logic                    chk_ok,
  output logic [AW+1:0]           rd_frame,
  output logic                    cmd_acc,
  output logic                    cmd_rej
);
  localparam int PW = $clog2(PAGE);
  localparam logic [2:0] OP_ARM = 3'd1, OP_SET = 3'd2, OP_CLR = 3'd3,
                         OP_LOCK = 3'd4, OP_READ = 3'd5;

  logic [AW-1:0] bound_q;
  logic flag_q, otp_q, armed_q;

  wire is_mod  = (cmd_op == OP_SET) || (cmd_op == OP_CLR) || (cmd_op == OP_LOCK);
  wire is_prot = is_mod || (cmd_op == OP_ARM) || (cmd_op == OP_READ);
  wire mod_ok  = armed_q && pre_pin && w_pin && !otp_q;
  wire arm_ok  = wel && pre_pin && w_pin;

  logic ok_now;
  always_comb begin
    case (cmd_op)
      OP_ARM:  ok_now = arm_ok;
      OP_READ: ok_now = pre_pin;
      default: ok_now = mod_ok;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bound_q <= '1;
      flag_q  <= 1'b1;
      otp_q   <= 1'b0;
      armed_q <= 1'b0;
      cmd_acc <= 1'b0;
      cmd_rej <= 1'b0;
    end else begin
      cmd_acc <= cmd_valid && is_prot && ok_now;
      cmd_rej <= cmd_valid && is_prot && !ok_now;
      if (cmd_valid) begin
        armed_q <= (cmd_op == OP_ARM) && arm_ok;
        if (is_mod && mod_ok) begin
          case (cmd_op)
            OP_SET: begin bound_q <= cmd_addr; flag_q <= 1'b0; end
            OP_CLR: begin bound_q <= '1;       flag_q <= 1'b1; end
            default: otp_q <= 1'b1;
          endcase
        end
      end
    end
  end

  function automatic logic hit(input logic [AW-1:0] a);
    return !flag_q && (a >= bound_q);
  endfunction

  logic [PAGE-1:0] word_bad;
  genvar i;
  generate
    for (i = 0; i < PAGE; i++) begin : g_word
      wire [PW-1:0] lo = chk_addr[PW-1:0] + PW'(i);
      assign word_bad[i] = (PW'(i) <= chk_words) && hit({chk_addr[AW-1:PW], lo});
    end
  endgenerate

  assign chk_prot = hit(chk_addr);
  assign chk_ok   = chk_all ? flag_q : ~|word_bad;
  assign rd_frame = {1'b0, bound_q, flag_q};

  AST_ACC_REJ_EXCL: assert property (@(posedge clk) disable iff (!por_n)
    !(cmd_acc && cmd_rej)); // R11
  AST_RESP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_acc || cmd_rej) |-> $past(cmd_valid)); // R11
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    otp_q |=> otp_q); // R7
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!por_n)
    otp_q |=> ($stable(bound_q) && $stable(flag_q))); // R7
  AST_ARM_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && cmd_op == OP_ARM) |=> ($stable(flag_q) && $stable(bound_q))); // R3
  AST_UNARMED_NO_CHANGE: assert property (@(posedge clk) disable iff (!por_n)
    (cmd_valid && !armed_q) |=> ($stable(bound_q) && $stable(flag_q))); // R6
endmodule

// File: tb/tb_wprot_unit.sv
module tb_wprot_unit;
  localparam int PERIOD = 10;
  logic clk = 0, por_n = 0, cmd_valid = 0, wel = 0, w_pin = 0, pre_pin = 0, chk_all = 0;
  logic [2:0] cmd_op = 0;
  logic [7:0] cmd_addr = 0, chk_addr = 0;
  logic [1:0] chk_words = 0;
  logic chk_prot, chk_ok, cmd_acc, cmd_rej;
  logic [9:0] rd_frame;
  int tests = 0, fails = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  wprot_unit dut (.clk(clk), .por_n(por_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wel(wel), .w_pin(w_pin), .pre_pin(pre_pin), .chk_addr(chk_addr),
    .chk_words(chk_words), .chk_all(chk_all), .chk_prot(chk_prot), .chk_ok(chk_ok),
    .rd_frame(rd_frame), .cmd_acc(cmd_acc), .cmd_rej(cmd_rej));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic ea,
                       input logic er, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0;
    check({tag, " acc"}, cmd_acc, ea);
    check({tag, " rej"}, cmd_rej, er);
  endtask

  task automatic probe(input logic [7:0] a, input logic [1:0] n, input logic all,
                       input logic eprot, input logic eok, input string tag);
    chk_addr = a; chk_words = n; chk_all = all;
    #1;
    check({tag, " prot"}, chk_prot, eprot);
    check({tag, " ok"}, chk_ok, eok);
  endtask

  task automatic do_reset;
    por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 frame", rd_frame, 10'h1FF);
    probe(8'h00, 2'd0, 0, 0, 1, "R1 addr0");
    probe(8'hFF, 2'd3, 0, 0, 1, "R1 page top");
  endtask

  task automatic t_arm;
    wel = 0; w_pin = 1; pre_pin = 1;
    issue(3'd1, 8'hC0, 0, 1, "R3 arm no wel");
    wel = 1; w_pin = 0;
    issue(3'd1, 8'hC0, 0, 1, "R3 arm w low");
    w_pin = 1;
    issue(3'd1, 8'hC0, 1, 0, "R3 arm ok");
    check("R3 flag kept", rd_frame, 10'h1FF);
  endtask

  task automatic t_set;
    issue(3'd2, 8'h40, 1, 0, "R4 set after arm");
    check("R4 frame", rd_frame, 10'h080);
    issue(3'd2, 8'h10, 0, 1, "R4 set unarmed");
    check("R4 frame kept", rd_frame, 10'h080);
    probe(8'h3F, 2'd0, 0, 0, 1, "R2 below");
    probe(8'h40, 2'd0, 0, 1, 0, "R2 at bound");
    probe(8'hFF, 2'd0, 0, 1, 0, "R2 top");
    probe(8'h00, 2'd0, 1, 0, 0, "R10 fill blocked");
    issue(3'd1, 8'hC0, 1, 0, "R4 arm");
    pre_pin = 0;
    issue(3'd2, 8'h10, 0, 1, "R4 set pre low");
    pre_pin = 1;
    check("R4 frame after pre low", rd_frame, 10'h080);
  endtask

  task automatic t_discard;
    issue(3'd1, 8'hC0, 1, 0, "R6 arm");
    issue(3'd0, 8'h00, 0, 0, "R11 other op silent");
    issue(3'd2, 8'h10, 0, 1, "R6 set after other");
    issue(3'd1, 8'hC0, 1, 0, "R6 arm2");
    issue(3'd5, 8'h00, 1, 0, "R6 read between");
    issue(3'd3, 8'hFF, 0, 1, "R6 clear after read");
    check("R6 frame kept", rd_frame, 10'h080);
  endtask

  task automatic t_page;
    issue(3'd1, 8'hC0, 1, 0, "R9 arm");
    issue(3'd2, 8'h3F, 1, 0, "R9 set 3F");
    probe(8'h3D, 2'd1, 0, 0, 1, "R9 3D x2");
    probe(8'h3D, 2'd2, 0, 0, 0, "R9 3D x3");
    probe(8'h3E, 2'd2, 0, 0, 0, "R9 3E x3 wrap");
    probe(8'h3F, 2'd3, 0, 1, 0, "R9 3F x4");
    probe(8'h3C, 2'd2, 0, 0, 1, "R9 3C x3");
  endtask

  task automatic t_clear;
    issue(3'd1, 8'hC0, 1, 0, "R5 arm");
    issue(3'd3, 8'hFF, 1, 0, "R5 clear");
    check("R5 frame", rd_frame, 10'h1FF);
    probe(8'hFF, 2'd0, 0, 0, 1, "R5 top free");
    probe(8'h00, 2'd0, 1, 0, 1, "R10 fill allowed");
  endtask

  task automatic t_read;
    pre_pin = 0;
    issue(3'd5, 8'h00, 0, 1, "R8 read pre low");
    pre_pin = 1;
    issue(3'd1, 8'hC0, 1, 0, "R8 arm");
    issue(3'd2, 8'hA5, 1, 0, "R8 set A5");
    issue(3'd5, 8'h00, 1, 0, "R8 read");
    for (int b = 9; b >= 0; b--)
      check($sformatf("R8 bit %0d", b), rd_frame[b], (b == 9) ? 1'b0 :
            (b == 0) ? 1'b0 : 8'hA5 >> (b - 1) & 1);
  endtask

  task automatic t_lock;
    issue(3'd1, 8'hC0, 1, 0, "R7 arm");
    issue(3'd2, 8'h20, 1, 0, "R7 set 20");
    issue(3'd1, 8'hC0, 1, 0, "R7 arm lock");
    issue(3'd4, 8'h00, 1, 0, "R7 lock");
    issue(3'd1, 8'hC0, 1, 0, "R7 arm after lock");
    issue(3'd2, 8'h80, 0, 1, "R7 set locked");
    issue(3'd1, 8'hC0, 1, 0, "R7 arm again");
    issue(3'd3, 8'hFF, 0, 1, "R7 clear locked");
    issue(3'd1, 8'hC0, 1, 0, "R7 arm third");
    issue(3'd4, 8'h00, 0, 1, "R7 relock");
    check("R7 frozen", rd_frame, 10'h040);
    do_reset();
    check("R1 frame after por", rd_frame, 10'h1FF);
    issue(3'd1, 8'hC0, 1, 0, "R7 arm after por");
    issue(3'd2, 8'h80, 1, 0, "R7 set after por");
    check("R7 unlocked frame", rd_frame, 10'h100);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_arm();
    t_set();
    t_discard();
    t_page();
    t_clear();
    t_read();
    t_lock();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule